// File: doc/BRIEF.md
# Clock Recovery Training Sequencer

This block runs the clock recovery phase of link training for one target on a serial display link. The target is either the final receiver or a single repeater. After a start pulse it repeats a fixed loop. First it drives the common lane drive settings (voltage swing and pre-emphasis) to the transmit PHY. Next it writes those settings to the target through an abstract command port. It then waits a programmable interval and reads back the per-lane lock status and the target's requested drive adjustments.

The loop ends in one of four ways:
- every active lane reports clock lock;
- the swing already stands at its highest level;
- the target asks for the unchanged swing too many times in a row;
- a total iteration cap is reached.

The end is signalled by a one-cycle done pulse with a result code. Reaching the iteration cap also raises a sticky error flag.

The command port is protocol-neutral. Each command is held valid until the environment returns a one-cycle response. The response to a status read carries the lock bits and the requested settings.

Top module: `crtrain_seq`

## Requirements
- R1: After reset `done`, `cmdValid`, `phyApply` and `errIterCap` are 0, and `phySwing` and `phyPreEmph` are 0.
- R2: Each iteration gives one `phyApply` cycle, then a write command, then the wait, then a status read (`cmdOp`=3, `cmdLen`=6), in that order.
- R3: The first write after start is a burst with pattern and settings (`cmdOp`=1, `cmdLen`=5). Every later write in the same run carries only the settings (`cmdOp`=2, `cmdLen`=4).
- R4: The number of cycles with `cmdValid` low between the write response and the read command is `rxInterval`*UNIT_WAIT when `rxRev12`=1 and `rxInterval`!=0, and BASE_WAIT otherwise. Configuration is captured at start.
- R5: Active lanes are set by `laneCfg`: 0 selects lane 0, 1 selects lanes 0-1, 2 or 3 select lanes 0-3 (bit i of `rspCrDone` is lane i). The run ends with result 0 (success) as soon as every active lane reports lock.
- R6: A run starts at swing 0 and pre-emphasis 0. After each unsuccessful iteration the next one applies the requested swing and pre-emphasis from the last read.
- R7: If the lanes are not all locked while the applied swing is 3 (the maximum), the run fails at once with no further iteration.
- R8: A counter rises when the requested swing equals the applied swing and clears otherwise. When it reaches 5, the run fails without raising `errIterCap`.
- R9: When the iteration count reaches 10, the run fails and `errIterCap` goes to 1. It stays 1 until reset, including through later runs.
- R10: The failure code is 2 when at least one active lane was locked in the last read, and 1 when none were. Code 3 never appears.
- R11: `done` is a one-cycle pulse, with no command or apply in that cycle. A `start` while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, returns to idle |
| start | input | 1 | Begins a run when idle |
| laneCfg | input | 2 | Active lane selection |
| rxRev12 | input | 1 | Target revision 1.2 or later |
| rxInterval | input | 8 | Target interval field |
| phyApply | output | 1 | Strobe to load drive settings into the PHY |
| phySwing | output | 2 | Voltage swing level |
| phyPreEmph | output | 2 | Pre-emphasis level |
| cmdValid | output | 1 | Command request, held until response |
| cmdOp | output | 2 | 1 burst write, 2 settings write, 3 status read |
| cmdLen | output | 3 | Byte count of the command |
| rspValid | input | 1 | One-cycle command response |
| rspCrDone | input | 4 | Per-lane clock lock bits from a status read |
| rspReqSwing | input | 2 | Requested swing from a status read |
| rspReqPreEmph | input | 2 | Requested pre-emphasis from a status read |
| done | output | 1 | End-of-run pulse |
| result | output | 2 | 0 success, 1 no lane locked, 2 some lanes locked |
| errIterCap | output | 1 | Sticky iteration-cap error |

## Verification
A wrong lane mask or a corrupted settings register shows up at the latest at the next `phyApply` or at the done pulse. A bad mask gives a wrong success or failure code, and a bad settings register gives a swing other than the one requested. Faults in the consecutive-swing counter or the iteration counter move the done pulse by at least one whole iteration, so the number of status reads before done is compared on every run. A miscounted wait timer changes the idle gap before the very first read of a run.

// File: rtl/crtrain_pkg.sv
package crtrain_pkg;

  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_FAIL_NONE = 2'd1,
    RES_FAIL_PART = 2'd2
  } crResult_e;

  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_BURST_WR  = 2'd1,
    OP_LANE_WR   = 2'd2,
    OP_STATUS_RD = 2'd3
  } crOp_e;

  localparam logic [2:0] LEN_BURST  = 3'd5;
  localparam logic [2:0] LEN_LANES  = 3'd4;
  localparam logic [2:0] LEN_STATUS = 3'd6;

  // control -> datapath strobes
  typedef struct packed {
    logic init;
    logic armWait;
    logic capture;
    logic advance;
    logic finishOk;
    logic finishFail;
  } crStrobe_t;

endpackage

// File: rtl/crtrain_ctrl.sv
module crtrain_ctrl
  import crtrain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rspValid,
  input  logic       waitDone,
  input  logic       allLocked,
  input  logic       atMaxSwing,
  input  logic       limitHit,
  input  logic       firstIter,
  output crStrobe_t  strobe,
  output logic       phyApply,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic [2:0] cmdLen
);

  typedef enum logic [2:0] {
    S_IDLE, S_APPLY, S_WRITE, S_WAIT, S_READ, S_EVAL, S_CHECK
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    phyApply = 1'b0;
    cmdValid = 1'b0;
    cmdOp    = OP_NONE;
    cmdLen   = 3'd0;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          strobe.init = 1'b1;
          stateD      = S_APPLY;
        end
      end
      S_APPLY: begin
        phyApply = 1'b1;
        stateD   = S_WRITE;
      end
      S_WRITE: begin
        cmdValid = 1'b1;
        cmdOp    = firstIter ? OP_BURST_WR : OP_LANE_WR;
        cmdLen   = firstIter ? LEN_BURST : LEN_LANES;
        if (rspValid) begin
          strobe.armWait = 1'b1;
          stateD         = S_WAIT;
        end
      end
      S_WAIT: begin
        if (waitDone) stateD = S_READ;
      end
      S_READ: begin
        cmdValid = 1'b1;
        cmdOp    = OP_STATUS_RD;
        cmdLen   = LEN_STATUS;
        if (rspValid) begin
          strobe.capture = 1'b1;
          stateD         = S_EVAL;
        end
      end
      S_EVAL: begin
        if (allLocked) begin
          strobe.finishOk = 1'b1;
          stateD          = S_IDLE;
        end else if (atMaxSwing) begin
          strobe.finishFail = 1'b1;
          stateD            = S_IDLE;
        end else begin
          strobe.advance = 1'b1;
          stateD         = S_CHECK;
        end
      end
      S_CHECK: begin
        if (limitHit) begin
          strobe.finishFail = 1'b1;
          stateD            = S_IDLE;
        end else begin
          stateD = S_APPLY;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

endmodule

// File: rtl/crtrain_dp.sv
module crtrain_dp
  import crtrain_pkg::*;
#(
  parameter int unsigned BASE_WAIT = 12500,
  parameter int unsigned UNIT_WAIT = 500000,
  parameter int unsigned ITER_CAP  = 10,
  parameter int unsigned SAME_CAP  = 5,
  parameter int unsigned FIELD_W   = 8,
  parameter int unsigned SWING_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  crStrobe_t          strobe,
  input  logic [1:0]         laneCfg,
  input  logic               rxRev12,
  input  logic [FIELD_W-1:0] rxInterval,
  input  logic [LANES-1:0]   rspCrDone,
  input  logic [SWING_W-1:0] rspReqSwing,
  input  logic [SWING_W-1:0] rspReqPreEmph,
  output logic               waitDone,
  output logic               allLocked,
  output logic               atMaxSwing,
  output logic               limitHit,
  output logic               firstIter,
  output logic [SWING_W-1:0] swingQ,
  output logic [SWING_W-1:0] preQ,
  output logic               doneQ,
  output logic [1:0]         resultQ,
  output logic               errQ
);

  localparam int unsigned WAIT_W = $clog2(((2**FIELD_W) - 1) * UNIT_WAIT + BASE_WAIT + 1);
  localparam int unsigned ITER_W = $clog2(ITER_CAP + 1);
  localparam int unsigned SAME_W = $clog2(SAME_CAP + 1);
  localparam logic [SWING_W-1:0] MAX_SWING = '1;

  logic [WAIT_W-1:0]  waitLen, waitLenQ, waitQ;
  logic [ITER_W-1:0]  iterQ;
  logic [SAME_W-1:0]  sameQ;
  logic [LANES-1:0]   maskD, maskQ, stsQ;
  logic [SWING_W-1:0] reqSwQ, reqPeQ;
  logic               iterCap;

  always_comb begin
    if (rxRev12 && rxInterval != '0)
      waitLen = WAIT_W'(rxInterval) * WAIT_W'(UNIT_WAIT);
    else
      waitLen = WAIT_W'(BASE_WAIT);
  end

  always_comb begin
    unique case (laneCfg)
      2'd0:    maskD = LANES'(4'b0001);
      2'd1:    maskD = LANES'(4'b0011);
      default: maskD = LANES'(4'b1111);
    endcase
  end

  assign waitDone   = (waitQ == WAIT_W'(1));
  assign allLocked  = ((stsQ & maskQ) == maskQ);
  assign atMaxSwing = (swingQ == MAX_SWING);
  assign iterCap    = (iterQ >= ITER_W'(ITER_CAP));
  assign limitHit   = iterCap || (sameQ >= SAME_W'(SAME_CAP));
  assign firstIter  = (iterQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitLenQ <= '0;
      waitQ    <= '0;
      iterQ    <= '0;
      sameQ    <= '0;
      maskQ    <= '0;
      stsQ     <= '0;
      reqSwQ   <= '0;
      reqPeQ   <= '0;
      swingQ   <= '0;
      preQ     <= '0;
      doneQ    <= 1'b0;
      resultQ  <= RES_OK;
      errQ     <= 1'b0;
    end else begin
      doneQ <= strobe.finishOk | strobe.finishFail;
      if (strobe.init) begin
        waitLenQ <= waitLen;
        maskQ    <= maskD;
        iterQ    <= '0;
        sameQ    <= '0;
        swingQ   <= '0;
        preQ     <= '0;
      end
      if (strobe.armWait)       waitQ <= waitLenQ;
      else if (waitQ != '0)     waitQ <= waitQ - WAIT_W'(1);
      if (strobe.capture) begin
        stsQ   <= rspCrDone;
        reqSwQ <= rspReqSwing;
        reqPeQ <= rspReqPreEmph;
      end
      if (strobe.advance) begin
        sameQ  <= (reqSwQ == swingQ) ? sameQ + SAME_W'(1) : '0;
        swingQ <= reqSwQ;
        preQ   <= reqPeQ;
        iterQ  <= iterQ + ITER_W'(1);
      end
      if (strobe.finishOk) resultQ <= RES_OK;
      if (strobe.finishFail) begin
        resultQ <= ((stsQ & maskQ) != '0) ? RES_FAIL_PART : RES_FAIL_NONE;
        if (iterCap) errQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/crtrain_seq.sv
module crtrain_seq
  import crtrain_pkg::*;
#(
  parameter int unsigned BASE_WAIT = 12500,
  parameter int unsigned UNIT_WAIT = 500000,
  parameter int unsigned ITER_CAP  = 10,
  parameter int unsigned SAME_CAP  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] laneCfg,
  input  logic       rxRev12,
  input  logic [7:0] rxInterval,
  output logic       phyApply,
  output logic [1:0] phySwing,
  output logic [1:0] phyPreEmph,
  output logic       cmdValid,
  output logic [1:0] cmdOp,
  output logic [2:0] cmdLen,
  input  logic       rspValid,
  input  logic [3:0] rspCrDone,
  input  logic [1:0] rspReqSwing,
  input  logic [1:0] rspReqPreEmph,
  output logic       done,
  output logic [1:0] result,
  output logic       errIterCap
);

  crStrobe_t strobe;
  logic waitDone, allLocked, atMaxSwing, limitHit, firstIter;

  crtrain_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rspValid(rspValid),
    .waitDone(waitDone), .allLocked(allLocked), .atMaxSwing(atMaxSwing),
    .limitHit(limitHit), .firstIter(firstIter), .strobe(strobe),
    .phyApply(phyApply), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen)
  );

  crtrain_dp #(
    .BASE_WAIT(BASE_WAIT), .UNIT_WAIT(UNIT_WAIT), .ITER_CAP(ITER_CAP),
    .SAME_CAP(SAME_CAP), .FIELD_W(8), .SWING_W(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .laneCfg(laneCfg),
    .rxRev12(rxRev12), .rxInterval(rxInterval), .rspCrDone(rspCrDone),
    .rspReqSwing(rspReqSwing), .rspReqPreEmph(rspReqPreEmph),
    .waitDone(waitDone), .allLocked(allLocked), .atMaxSwing(atMaxSwing),
    .limitHit(limitHit), .firstIter(firstIter), .swingQ(phySwing),
    .preQ(phyPreEmph), .doneQ(done), .resultQ(result), .errQ(errIterCap)
  );

endmodule

// File: rtl/crtrain_chk.sv
module crtrain_chk (
  input logic       clk,
  input logic       rstN,
  input logic       phyApply,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input logic [1:0] phySwing,
  input logic [1:0] phyPreEmph,
  input logic       done,
  input logic [1:0] result,
  input logic       errIterCap
);

  AST_APPLY_NOT_CMD: assert property (@(posedge clk) disable iff (!rstN)
    phyApply |-> !cmdValid); // R2

  AST_APPLY_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    phyApply |=> (cmdValid && (cmdOp == 2'd1 || cmdOp == 2'd2))); // R2

  AST_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($stable(phySwing) && $stable(phyPreEmph))); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errIterCap |=> errIterCap); // R9

  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (result != 2'd3)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!cmdValid && !phyApply)); // R11

endmodule

bind crtrain_seq crtrain_chk u_chk (
  .clk(clk), .rstN(rstN), .phyApply(phyApply), .cmdValid(cmdValid),
  .cmdOp(cmdOp), .phySwing(phySwing), .phyPreEmph(phyPreEmph),
  .done(done), .result(result), .errIterCap(errIterCap)
);

// File: tb/sim_crtrain_seq.sv
`timescale 1ns/1ps
module sim_crtrain_seq;

  localparam int BASE = 4;
  localparam int UNIT = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] laneCfg = '0;
  logic       rxRev12 = 1'b0;
  logic [7:0] rxInterval = '0;
  logic       phyApply, cmdValid, done, errIterCap;
  logic [1:0] phySwing, phyPreEmph, cmdOp, result;
  logic [2:0] cmdLen;
  logic       rspValid = 1'b0;
  logic [3:0] rspCrDone = '0;
  logic [1:0] rspReqSwing = '0, rspReqPreEmph = '0;

  always #4 clk = ~clk;

  crtrain_seq #(.BASE_WAIT(BASE), .UNIT_WAIT(UNIT), .ITER_CAP(10), .SAME_CAP(5)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .laneCfg(laneCfg), .rxRev12(rxRev12),
    .rxInterval(rxInterval), .phyApply(phyApply), .phySwing(phySwing),
    .phyPreEmph(phyPreEmph), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen),
    .rspValid(rspValid), .rspCrDone(rspCrDone), .rspReqSwing(rspReqSwing),
    .rspReqPreEmph(rspReqPreEmph), .done(done), .result(result), .errIterCap(errIterCap)
  );

  int checks = 0;
  int errors = 0;

  logic [3:0] sts   [0:11];
  logic [1:0] reqSw [0:11];
  logic [1:0] reqPe [0:11];
  int  wrCount, rdCount, expWait;
  bit  sawApply;
  bit  stickyExp = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model: answers commands and checks ordering, ops and settings
  task automatic responder();
    int gap = 0;
    bit inWait = 0;
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      if (phyApply) begin
        sawApply = 1;
        chk(phySwing == ((wrCount == 0) ? 2'd0 : reqSw[wrCount-1]), "R6 swing", int'(phySwing),
            (wrCount == 0) ? 0 : int'(reqSw[wrCount-1]));
        chk(phyPreEmph == ((wrCount == 0) ? 2'd0 : reqPe[wrCount-1]), "R6 preemph", int'(phyPreEmph),
            (wrCount == 0) ? 0 : int'(reqPe[wrCount-1]));
      end else if (cmdValid && cmdOp != 2'd3) begin
        chk(sawApply, "R2 apply before write", int'(sawApply), 1);
        chk(cmdOp == ((wrCount == 0) ? 2'd1 : 2'd2), "R3 write op", int'(cmdOp), (wrCount == 0) ? 1 : 2);
        chk(cmdLen == ((wrCount == 0) ? 3'd5 : 3'd4), "R3 write len", int'(cmdLen), (wrCount == 0) ? 5 : 4);
        sawApply = 0;
        wrCount++;
        gap = 0;
        inWait = 1;
        rspValid = 1'b1;
      end else if (cmdValid) begin
        chk(inWait, "R2 read after write", int'(inWait), 1);
        chk(gap == expWait, "R4 wait gap", gap, expWait);
        chk(cmdLen == 3'd6, "R2 read len", int'(cmdLen), 6);
        rspCrDone     = sts[rdCount];
        rspReqSwing   = reqSw[rdCount];
        rspReqPreEmph = reqPe[rdCount];
        rdCount++;
        inWait = 0;
        rspValid = 1'b1;
      end else if (inWait) begin
        gap++;
      end
    end
  endtask

  function automatic void model(input logic [3:0] mask, output int iters,
                                output int res, output bit cap);
    int cur = 0;
    int same = 0;
    cap = 0;
    iters = 0;
    res = 0;
    for (int k = 0; k < 12; k++) begin
      if ((sts[k] & mask) == mask) begin iters = k + 1; res = 0; return; end
      if (cur == 3) begin iters = k + 1; res = ((sts[k] & mask) != 0) ? 2 : 1; return; end
      same = (int'(reqSw[k]) == cur) ? same + 1 : 0;
      cur = int'(reqSw[k]);
      if (k + 1 >= 10) begin iters = k + 1; cap = 1; res = ((sts[k] & mask) != 0) ? 2 : 1; return; end
      if (same >= 5) begin iters = k + 1; res = ((sts[k] & mask) != 0) ? 2 : 1; return; end
    end
  endfunction

  task automatic runCase(input logic [1:0] cfg, input bit rev, input logic [7:0] fld,
                         input int pokeAt, input string tag);
    logic [3:0] mask;
    int eIters, eRes, cyc;
    bit eCap, seen;
    mask = (cfg == 2'd0) ? 4'b0001 : (cfg == 2'd1) ? 4'b0011 : 4'b1111;
    model(mask, eIters, eRes, eCap);
    stickyExp = stickyExp | eCap;
    expWait = (rev && fld != 0) ? int'(fld) * UNIT : BASE;
    wrCount = 0; rdCount = 0; sawApply = 0;
    @(negedge clk);
    laneCfg = cfg; rxRev12 = rev; rxInterval = fld; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    cyc = 0;
    while (!seen && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == pokeAt) ? 1'b1 : 1'b0;
      if (done) seen = 1;
    end
    start = 1'b0;
    chk(seen, {tag, " done seen"}, int'(seen), 1);
    chk(int'(result) == eRes, {tag, " result"}, int'(result), eRes);
    chk(rdCount == eIters, {tag, " iterations"}, rdCount, eIters);
    chk(errIterCap == stickyExp, {tag, " R9 err flag"}, int'(errIterCap), int'(stickyExp));
    @(negedge clk);
    chk(!done, "R11 done pulse width", int'(done), 0);
  endtask

  task automatic fillAll(input logic [3:0] s, input logic [1:0] sw, input logic [1:0] pe);
    for (int k = 0; k < 12; k++) begin sts[k] = s; reqSw[k] = sw; reqPe[k] = pe; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fillAll(4'h0, 2'd0, 2'd0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !cmdValid && !phyApply && !errIterCap, "R1 idle outputs", int'({done, cmdValid, phyApply, errIterCap}), 0);
    chk(phySwing == 0 && phyPreEmph == 0, "R1 drive zero", int'({phySwing, phyPreEmph}), 0);
    rstN = 1'b1;
    fork responder(); join_none

    // R4 interval selection, immediate success R5
    fillAll(4'hF, 2'd0, 2'd0);
    runCase(2'd2, 1'b0, 8'd5, 0, "R4 old rev");
    runCase(2'd2, 1'b1, 8'd0, 0, "R4 zero field");
    runCase(2'd2, 1'b1, 8'd2, 0, "R4 field2");
    runCase(2'd2, 1'b1, 8'd7, 0, "R4 field7");

    // R5 R7 R10 lane sweep: swing jumps to max, then a second read decides
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 16; p++) begin
        fillAll(4'(p), 2'd3, 2'd1);
        runCase(2'(c), 1'b0, 8'd0, 0, "R5 R7 R10 sweep");
      end
    end

    // R6 climbing swing with success on third read
    fillAll(4'h1, 2'd0, 2'd0);
    reqSw[0] = 2'd1; reqPe[0] = 2'd2;
    reqSw[1] = 2'd2; reqPe[1] = 2'd3;
    sts[2] = 4'hF;
    runCase(2'd3, 1'b0, 8'd0, 0, "R6 climb");

    // R8 same swing five times, R11 start pulse ignored mid-run
    fillAll(4'h0, 2'd0, 2'd0);
    for (int k = 0; k < 12; k++) reqPe[k] = 2'(k);
    runCase(2'd1, 1'b0, 8'd0, 15, "R8 same swing");

    // R9 iteration cap with alternating swing
    fillAll(4'h1, 2'd0, 2'd1);
    for (int k = 0; k < 12; k++) reqSw[k] = 2'(k % 2);
    runCase(2'd2, 1'b0, 8'd0, 0, "R9 cap");

    // R9 flag remains through a clean run
    fillAll(4'hF, 2'd0, 2'd0);
    runCase(2'd0, 1'b0, 8'd0, 0, "R9 sticky");

    // R9 cleared by reset, R1
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(!errIterCap, "R9 cleared by reset", int'(errIterCap), 0);
    rstN = 1'b1;
    stickyExp = 0;
    runCase(2'd1, 1'b1, 8'd1, 0, "R1 after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule